// File: doc/BRIEF.md
# Mode-Banked Register File with Access Checks

This block holds the registers that a 32-bit processor keeps separately for each execution mode. It has two copies of R8–R12 (user and fast-interrupt), a stack pointer (R13) for every bank, a link register (R14) for every bank except the hypervisor bank, a saved status word for every bank except user, and one hypervisor exception-return address. One request per cycle names a target mode, a register number and, for writes, 32-bit data.

Before any storage is touched, the request is checked against the processor's current mode. A request that fails the check raises `undef` in the same cycle. A rejected write changes nothing. A rejected read returns zero with `rd_valid` low. The request channel has no back-pressure: every cycle with `req_valid` high is served in that cycle, so no ready signal exists. Mode codes on `cur_mode` and `req_tgt` are: USR=0, FIQ=1, IRQ=2, SVC=3, ABT=4, UND=5, MON=6, HYP=7, SYS=8. Codes 9–15 are illegal. SYS is never a valid target, because the user bank serves SYS as well.

Register numbers: 8–12 select R8–R12, 13 selects the stack pointer, 14 the link register, 16 the saved status word and 17 the hypervisor return address.

Top module: `banked_regfile`

## Requirements
- R1: After reset every stored register reads as zero, and a reset applied later clears all registers again.
- R2: A request whose current mode equals its target mode raises `undef`. This rule takes precedence over every permission below.
- R3: With target USR (code 0), register numbers 8–12 are accepted only when the current mode is FIQ (code 1).
- R4: With target USR, register 13 is rejected from SYS (code 8), and register 14 is rejected from HYP (code 7) or SYS.
- R5: With target HYP (code 7), register 17 is accepted only from HYP or MON (code 6), so under R2 it is accepted only from MON. Registers 13 and 16 of the HYP bank are accepted only from MON.
- R6: Registers 13, 14 and 16 each select that register in the target mode's own bank. A write to one bank or one register does not change any other.
- R7: Register 17 selects one unbanked hypervisor return address.
- R8: R8–R12 exist as separate user and FIQ copies. Any other target mode with numbers 8–12 raises `undef`.
- R9: The request raises `undef` if it names a register that does not exist: number 16 with target USR, number 14 with target HYP, number 17 with a target other than HYP, a number outside 8–14/16/17, target code 8 or above, or a current mode code above 8.
- R10: A rejected write leaves all storage unchanged. A rejected read drives `rd_data` to zero with `rd_valid` low.
- R11: An accepted write takes effect at the clock edge that ends the request cycle. A read is combinational: `rd_valid` and `rd_data` follow in the same cycle.
- R12: With `req_valid` low, `undef` and `rd_valid` are low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_mode | input | 4 | Current processor mode code |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tgt | input | 4 | Target mode code |
| req_regno | input | 5 | Register number (8–14, 16, 17) |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Accepted read; rd_data holds the value |
| rd_data | output | 32 | Read data, zero unless rd_valid |
| undef | output | 1 | Request rejected by the access check |

## Verification
The bench targets the cases where the permission depends on the current mode and the target together. A design that checked only the address would let SVC reach user R8, let SYS reach user R13, or let HYP reach its own return address, and `undef` would stay low in those cases. Bank aliasing is also checked: user R9 must read zero after a write to FIQ R9, and the ABT link register must read zero after a write to the ABT saved status. A design that folded these registers into one slot would return the written value. Rejected writes are followed by reads of the same register, so a write that was not blocked shows up as a changed value.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;

  typedef enum logic [3:0] {
    M_USR = 4'd0, M_FIQ = 4'd1, M_IRQ = 4'd2, M_SVC = 4'd3,
    M_ABT = 4'd4, M_UND = 4'd5, M_MON = 4'd6, M_HYP = 4'd7,
    M_SYS = 4'd8
  } mode_e;

  localparam int NUM_BANKS   = 8;
  localparam int NUM_LO_REGS = 5;
  localparam int BASE_FIQLO  = NUM_LO_REGS;
  localparam int BASE_SP     = 2 * NUM_LO_REGS;
  localparam int BASE_LR     = BASE_SP + NUM_BANKS;
  localparam int BASE_PSR    = BASE_LR + NUM_BANKS - 1 - 1;
  localparam int SLOT_ELR    = BASE_PSR + NUM_BANKS;
  localparam int NUM_SLOTS   = SLOT_ELR + 1;
  localparam int SLOT_W      = $clog2(NUM_SLOTS);

  localparam logic [4:0] RN_LO_FIRST = 5'd8;
  localparam logic [4:0] RN_LO_LAST  = 5'd12;
  localparam logic [4:0] RN_SP       = 5'd13;
  localparam logic [4:0] RN_LR       = 5'd14;
  localparam logic [4:0] RN_PSR      = 5'd16;
  localparam logic [4:0] RN_ELR      = 5'd17;

endpackage

// File: rtl/bank_access_check.sv
module bank_access_check
  import banked_regfile_pkg::*;
(
  input  logic [3:0]        cur_mode,
  input  logic [3:0]        tgt_mode,
  input  logic [4:0]        regno,
  output logic              allowed,
  output logic [SLOT_W-1:0] slot
);

  logic             exists;
  logic             perm;
  logic [SLOT_W-1:0] bank;

  assign bank = SLOT_W'(tgt_mode[2:0]);

  always_comb begin
    exists = 1'b0;
    slot   = '0;
    if (tgt_mode < 4'd8) begin
      if (regno >= RN_LO_FIRST && regno <= RN_LO_LAST) begin
        if (tgt_mode == M_USR) begin
          exists = 1'b1;
          slot   = SLOT_W'(regno - RN_LO_FIRST);
        end else if (tgt_mode == M_FIQ) begin
          exists = 1'b1;
          slot   = SLOT_W'(BASE_FIQLO) + SLOT_W'(regno - RN_LO_FIRST);
        end
      end else if (regno == RN_SP) begin
        exists = 1'b1;
        slot   = SLOT_W'(BASE_SP) + bank;
      end else if (regno == RN_LR) begin
        exists = (tgt_mode != M_HYP);
        slot   = SLOT_W'(BASE_LR) + bank;
      end else if (regno == RN_PSR) begin
        exists = (tgt_mode != M_USR);
        slot   = SLOT_W'(BASE_PSR) + bank;
      end else if (regno == RN_ELR) begin
        exists = (tgt_mode == M_HYP);
        slot   = SLOT_W'(SLOT_ELR);
      end
    end
  end

  always_comb begin
    perm = (cur_mode <= 4'd8) && (cur_mode != tgt_mode);
    if (tgt_mode == M_USR) begin
      if (regno >= RN_LO_FIRST && regno <= RN_LO_LAST)
        perm = perm && (cur_mode == M_FIQ);
      else if (regno == RN_SP)
        perm = perm && (cur_mode != M_SYS);
      else if (regno == RN_LR)
        perm = perm && (cur_mode != M_HYP) && (cur_mode != M_SYS);
    end else if (tgt_mode == M_HYP) begin
      if (regno == RN_ELR)
        perm = perm && (cur_mode == M_HYP || cur_mode == M_MON);
      else
        perm = perm && (cur_mode == M_MON);
    end
  end

  assign allowed = exists && perm;

  always_comb begin
    assert_same_mode_R2: assert (!(allowed && cur_mode == tgt_mode));
    assert_slot_range_R9: assert (!allowed || slot < SLOT_W'(NUM_SLOTS));
  end

endmodule

// File: rtl/bank_storage.sv
module bank_storage #(
  parameter int DATA_W = 32,
  parameter int NSLOT  = 33,
  localparam int IDX_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] slots [NSLOT]
);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slots[g] <= '0;
      else if (we && widx == IDX_W'(g))
        slots[g] <= wdata;
    end
  end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_regfile_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cur_mode,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [3:0]        req_tgt,
  input  logic [4:0]        req_regno,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              undef
);

  logic              allowed;
  logic [SLOT_W-1:0] slot;
  logic              wr_en;
  logic [DATA_W-1:0] slots [NUM_SLOTS];

  bank_access_check u_check (
    .cur_mode (cur_mode),
    .tgt_mode (req_tgt),
    .regno    (req_regno),
    .allowed  (allowed),
    .slot     (slot)
  );

  assign wr_en = req_valid && req_write && allowed;

  bank_storage #(.DATA_W(DATA_W), .NSLOT(NUM_SLOTS)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .widx  (slot),
    .wdata (req_wdata),
    .slots (slots)
  );

  assign undef    = req_valid && !allowed;
  assign rd_valid = req_valid && !req_write && allowed;
  assign rd_data  = rd_valid ? slots[slot] : '0;

  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, undef}));

  assert_rejected_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> rd_data == '0);

  assert_rejected_write_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (undef && req_write) |=> $stable(slots[slot]));

  assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> slots[$past(slot)] == $past(req_wdata));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!undef && !rd_valid && rd_data == '0));

  assert_same_mode_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cur_mode == req_tgt) |-> undef);

endmodule

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;

  typedef struct packed {
    logic [3:0]  cur;
    logic [3:0]  tgt;
    logic [4:0]  rn;
    logic        wr;
    logic [31:0] d;
    logic        eu;
    logic [31:0] ed;
  } vec_t;

  // mode codes: USR0 FIQ1 IRQ2 SVC3 ABT4 UND5 MON6 HYP7 SYS8
  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{4'd3, 4'd1, 5'd13, 1'b0, 32'h0,        1'b0, 32'h0},        // R1 fresh read
    '{4'd3, 4'd1, 5'd13, 1'b1, 32'hA1A1_0001, 1'b0, 32'h0},       // R6
    '{4'd3, 4'd2, 5'd13, 1'b1, 32'hB2B2_0002, 1'b0, 32'h0},       // R6
    '{4'd3, 4'd1, 5'd13, 1'b0, 32'h0,        1'b0, 32'hA1A1_0001}, // R6 fiq sp
    '{4'd3, 4'd2, 5'd13, 1'b0, 32'h0,        1'b0, 32'hB2B2_0002}, // R6 irq sp
    '{4'd1, 4'd0, 5'd8,  1'b1, 32'hC3C3_0003, 1'b0, 32'h0},       // R3 from FIQ
    '{4'd3, 4'd0, 5'd8,  1'b1, 32'hDEAD_BEEF, 1'b1, 32'h0},       // R3 from SVC
    '{4'd1, 4'd0, 5'd8,  1'b0, 32'h0,        1'b0, 32'hC3C3_0003}, // R10 unchanged
    '{4'd0, 4'd1, 5'd9,  1'b1, 32'hD4D4_0004, 1'b0, 32'h0},       // R8 fiq r9
    '{4'd1, 4'd0, 5'd9,  1'b0, 32'h0,        1'b0, 32'h0},        // R8 usr r9 separate
    '{4'd3, 4'd2, 5'd10, 1'b0, 32'h0,        1'b1, 32'h0},        // R8 irq r10
    '{4'd8, 4'd0, 5'd13, 1'b0, 32'h0,        1'b1, 32'h0},        // R4 SYS->usr sp
    '{4'd7, 4'd0, 5'd13, 1'b0, 32'h0,        1'b0, 32'h0},        // R4 HYP->usr sp ok
    '{4'd7, 4'd0, 5'd14, 1'b0, 32'h0,        1'b1, 32'h0},        // R4 HYP->usr lr
    '{4'd6, 4'd0, 5'd14, 1'b1, 32'hE5E5_0005, 1'b0, 32'h0},       // R4 MON->usr lr
    '{4'd3, 4'd0, 5'd14, 1'b0, 32'h0,        1'b0, 32'hE5E5_0005}, // R4 read back
    '{4'd6, 4'd7, 5'd17, 1'b1, 32'hF6F6_0006, 1'b0, 32'h0},       // R5 elr from MON
    '{4'd7, 4'd7, 5'd17, 1'b0, 32'h0,        1'b1, 32'h0},        // R2 HYP->HYP elr
    '{4'd3, 4'd7, 5'd17, 1'b0, 32'h0,        1'b1, 32'h0},        // R5 SVC->elr
    '{4'd3, 4'd7, 5'd13, 1'b1, 32'h1111_1111, 1'b1, 32'h0},       // R5 SVC->hyp sp
    '{4'd6, 4'd7, 5'd13, 1'b1, 32'h7777_0007, 1'b0, 32'h0},       // R5 MON->hyp sp
    '{4'd5, 4'd4, 5'd16, 1'b1, 32'h8888_0008, 1'b0, 32'h0},       // R6 abt psr
    '{4'd5, 4'd4, 5'd16, 1'b0, 32'h0,        1'b0, 32'h8888_0008}, // R6
    '{4'd5, 4'd4, 5'd14, 1'b0, 32'h0,        1'b0, 32'h0},        // R6 abt lr distinct
    '{4'd2, 4'd2, 5'd13, 1'b0, 32'h0,        1'b1, 32'h0},        // R2 IRQ->IRQ
    '{4'd3, 4'd0, 5'd16, 1'b0, 32'h0,        1'b1, 32'h0},        // R9 usr psr
    '{4'd6, 4'd7, 5'd14, 1'b0, 32'h0,        1'b1, 32'h0},        // R9 hyp lr
    '{4'd6, 4'd3, 5'd17, 1'b0, 32'h0,        1'b1, 32'h0},        // R9 svc elr
    '{4'd3, 4'd1, 5'd15, 1'b0, 32'h0,        1'b1, 32'h0},        // R9 regno 15
    '{4'd3, 4'd8, 5'd13, 1'b0, 32'h0,        1'b1, 32'h0},        // R9 SYS target
    '{4'd6, 4'd7, 5'd13, 1'b0, 32'h0,        1'b0, 32'h7777_0007}, // R5 hyp sp
    '{4'd6, 4'd7, 5'd17, 1'b0, 32'h0,        1'b0, 32'hF6F6_0006}  // R7 elr
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cur_mode = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_tgt = '0;
  logic [4:0]  req_regno = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        undef;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode), .req_valid(req_valid),
    .req_write(req_write), .req_tgt(req_tgt), .req_regno(req_regno),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .undef(undef)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [3:0] t, input logic [4:0] r,
                       input logic w, input logic [31:0] d);
    @(negedge clk);
    cur_mode = c; req_tgt = t; req_regno = r; req_write = w; req_wdata = d;
    req_valid = 1'b1;
    #1;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 idle after reset
    @(negedge clk); #1;
    check("R12 idle undef", {31'b0, undef}, 32'h0);
    check("R12 idle rd_valid", {31'b0, rd_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].cur, VEC[i].tgt, VEC[i].rn, VEC[i].wr, VEC[i].d);
      check($sformatf("R%0d-vec%0d undef", 9, i), {31'b0, undef}, {31'b0, VEC[i].eu});
      check($sformatf("vec%0d rd_valid R11", i), {31'b0, rd_valid},
            {31'b0, !VEC[i].wr && !VEC[i].eu});
      check($sformatf("vec%0d rd_data R11", i), rd_data,
            (VEC[i].wr || VEC[i].eu) ? 32'h0 : VEC[i].ed);
    end

    // R9 illegal current-mode code
    drive(4'd12, 4'd3, 5'd13, 1'b0, 32'h0);
    check("R9 bad cur mode", {31'b0, undef}, 32'h1);

    // R12 valid low with otherwise legal fields
    @(negedge clk); req_valid = 1'b0; cur_mode = 4'd6; req_tgt = 4'd7; req_regno = 5'd17;
    #1;
    check("R12 no req rd_data", rd_data, 32'h0);
    check("R12 no req undef", {31'b0, undef}, 32'h0);

    // R1 reset later clears storage
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    drive(4'd6, 4'd7, 5'd17, 1'b0, 32'h0);
    check("R1 elr cleared", rd_data, 32'h0);
    check("R1 read valid", {31'b0, rd_valid}, 32'h1);
    drive(4'd3, 4'd1, 5'd13, 1'b0, 32'h0);
    check("R1 fiq sp cleared", rd_data, 32'h0);

    @(negedge clk); req_valid = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule